// File: doc/BRIEF.md
# Interrupt Context Integrity Monitor

This block sits beside an 8051-style core as a debug checker and watches the core's observation strobes for programming errors. When an interrupt is taken it stores the stack pointer, accumulator and status word into a snapshot slot for that interrupt's priority level. When the handler returns, it compares the live values with that slot. There is one slot per level, so a high-priority handler nested inside a low-priority one is checked against its own entry values.

It also checks every push and pop for a stack pointer that wraps around, and for a stack that grows into the upper half of internal memory when that half is absent. On each opcode fetch it traps the single undefined opcode and the redundant move of the accumulator register into A.

Each check has its own enable bit. The first event found is latched as a 3-bit code and held until a clear strobe. A halt request follows that code.

Top module: `ictx_guard`

## Requirements
- R1: When enabled by `enMask[0]`, a return whose `obsSp` differs from the value captured at entry to that handler sets code 1.
- R2: When enabled by `enMask[1]`, a return whose `obsAcc` differs from the value captured at entry sets code 2.
- R3: When enabled by `enMask[2]`, a return whose `obsPsw` differs from the value captured at entry, with bits 5 and 1 ignored, sets code 3.
- R4: When enabled by `enMask[3]`, a push (`stackPush`=1) with `spAfter` < `spBefore`, or a pop with `spAfter` > `spBefore`, sets code 4.
- R5: When enabled by `enMask[3]`, a push whose `spAfter` bit 7 is 1 while `upperPresent` is 0 sets code 4.
- R6: A fetch of opcode 0xA5 sets code 5 when `enMask[4]` is 1. When that bit is 0 the fetch flags nothing.
- R7: When enabled by `enMask[5]`, a fetch of opcode 0xE5 with operand 0xE0 (move from the accumulator register into A) sets code 6.
- R8: With its enable bit at 0, none of the six checks changes `excCode`.
- R9: Two snapshot slots are kept, one for level 0 and one for level 1. A return checks against, and retires, the highest level that has an outstanding entry.
- R10: A return with no outstanding entry is ignored by R1 to R3.
- R11: A detected event is loaded only while `excCode` is 0, and the code is then held until `clearCode`. When several events fall in one cycle, the lowest code wins. If `clearCode` and an event fall in the same cycle, the event's code is loaded. `haltReq` is 1 exactly while `excCode` is non-zero.
- R12: After reset, `excCode` is 0, `haltReq` is 0 and no entry is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enMask | input | 6 | Per-check enables: 0 SP, 1 ACC, 2 PSW, 3 stack, 4 undefined opcode, 5 redundant move |
| upperPresent | input | 1 | 1 when the upper 128 bytes of internal memory exist |
| irqTake | input | 1 | Interrupt entry strobe |
| irqLevel | input | 1 | Priority level of the interrupt being entered |
| retiExec | input | 1 | Return-from-interrupt strobe |
| obsSp | input | 8 | Current stack pointer |
| obsAcc | input | 8 | Current accumulator |
| obsPsw | input | 8 | Current status word |
| stackOp | input | 1 | Push or pop strobe |
| stackPush | input | 1 | 1 for push, 0 for pop |
| spBefore | input | 8 | Stack pointer before the stack operation |
| spAfter | input | 8 | Stack pointer after the stack operation |
| fetchValid | input | 1 | Opcode fetch strobe |
| fetchOp | input | 8 | Fetched opcode |
| fetchArg | input | 8 | First operand byte |
| clearCode | input | 1 | Clears the latched code |
| excCode | output | 3 | Latched exception code, 0 when none |
| haltReq | output | 1 | Halt request to the core |

## Verification
A return can fall in the same cycle as a stack pop that wraps and an opcode fetch, because the core reports all of these at once. The bench drives a handler return that mismatches in both SP and ACC at once, and expects code 1. It also drives a wrapping pop together with the undefined opcode, and expects code 4. It then drives a clear strobe in the same cycle as a fresh undefined-opcode fetch, and checks that code 5 is loaded rather than 0. Finally, it checks that a later event does not replace a code that is already held.

// File: rtl/ictx_pkg.sv
package ictx_pkg;
  localparam int LVL_N = 2;
  localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1;
  localparam int EV_N  = 6;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE  = 3'd0,
    EXC_SP    = 3'd1,
    EXC_ACC   = 3'd2,
    EXC_PSW   = 3'd3,
    EXC_STACK = 3'd4,
    EXC_ILLOP = 3'd5,
    EXC_MOVAA = 3'd6
  } excCode_e;

  typedef struct packed {
    logic [LVL_N-1:0] capEn;
    logic             chkValid;
    logic [LVL_W-1:0] chkLevel;
  } ictxStrobes_t;
endpackage

// File: rtl/ictx_datapath.sv
module ictx_datapath
  import ictx_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] PSW_USER_MASK = 8'h22,
  parameter logic [DW-1:0] ILL_OP = 8'hA5,
  parameter logic [DW-1:0] MOV_DIR_OP = 8'hE5,
  parameter logic [DW-1:0] ACC_ADDR = 8'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ictxStrobes_t      stb,
  input  logic [EV_N-1:0]   enMask,
  input  logic              upperPresent,
  input  logic [DW-1:0]     obsSp,
  input  logic [DW-1:0]     obsAcc,
  input  logic [DW-1:0]     obsPsw,
  input  logic              stackOp,
  input  logic              stackPush,
  input  logic [DW-1:0]     spBefore,
  input  logic [DW-1:0]     spAfter,
  input  logic              fetchValid,
  input  logic [DW-1:0]     fetchOp,
  input  logic [DW-1:0]     fetchArg,
  output logic [EV_N-1:0]   evVec
);
  logic [DW-1:0] slotSp  [LVL_N];
  logic [DW-1:0] slotAcc [LVL_N];
  logic [DW-1:0] slotPsw [LVL_N];

  for (genvar g = 0; g < LVL_N; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotSp[g]  <= '0;
        slotAcc[g] <= '0;
        slotPsw[g] <= '0;
      end else if (stb.capEn[g]) begin
        slotSp[g]  <= obsSp;
        slotAcc[g] <= obsAcc;
        slotPsw[g] <= obsPsw & ~PSW_USER_MASK;
      end
    end
  end

  logic wrapHit, upperHit;
  always_comb begin
    wrapHit  = stackOp && (stackPush ? (spAfter < spBefore) : (spAfter > spBefore));
    upperHit = stackOp && stackPush && spAfter[DW-1] && !upperPresent;
    evVec[0] = enMask[0] && stb.chkValid && (obsSp  != slotSp[stb.chkLevel]);
    evVec[1] = enMask[1] && stb.chkValid && (obsAcc != slotAcc[stb.chkLevel]);
    evVec[2] = enMask[2] && stb.chkValid &&
               ((obsPsw & ~PSW_USER_MASK) != slotPsw[stb.chkLevel]);
    evVec[3] = enMask[3] && (wrapHit || upperHit);
    evVec[4] = enMask[4] && fetchValid && (fetchOp == ILL_OP);
    evVec[5] = enMask[5] && fetchValid && (fetchOp == MOV_DIR_OP) && (fetchArg == ACC_ADDR);
  end
endmodule

// File: rtl/ictx_control.sv
module ictx_control
  import ictx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqTake,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              retiExec,
  input  logic              clearCode,
  input  logic [EV_N-1:0]   evVec,
  output ictxStrobes_t      stb,
  output logic [CODE_W-1:0] excCode,
  output logic              haltReq
);
  logic [LVL_N-1:0] activeQ, activeD;
  logic [CODE_W-1:0] codeQ, pick;
  logic hasAct;
  logic [LVL_W-1:0] topLvl;

  always_comb begin
    hasAct = 1'b0;
    topLvl = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (activeQ[i]) begin
        hasAct = 1'b1;
        topLvl = LVL_W'(i);
      end
    end
    stb.chkValid = retiExec && hasAct;
    stb.chkLevel = topLvl;
    for (int i = 0; i < LVL_N; i++) begin
      stb.capEn[i] = irqTake && (irqLevel == LVL_W'(i));
    end
    activeD = activeQ;
    if (stb.chkValid) activeD[topLvl] = 1'b0;
    activeD = activeD | stb.capEn;
  end

  always_comb begin
    pick = EXC_NONE;
    for (int i = EV_N - 1; i >= 0; i--) begin
      if (evVec[i]) pick = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '0;
      codeQ   <= EXC_NONE;
    end else begin
      activeQ <= activeD;
      if (clearCode || codeQ == EXC_NONE) codeQ <= pick;
    end
  end

  assign excCode = codeQ;
  assign haltReq = |codeQ;
endmodule

// File: rtl/ictx_guard.sv
module ictx_guard
  import ictx_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] PSW_USER_MASK = 8'h22,
  parameter logic [DW-1:0] ILL_OP = 8'hA5,
  parameter logic [DW-1:0] MOV_DIR_OP = 8'hE5,
  parameter logic [DW-1:0] ACC_ADDR = 8'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EV_N-1:0]   enMask,
  input  logic              upperPresent,
  input  logic              irqTake,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              retiExec,
  input  logic [DW-1:0]     obsSp,
  input  logic [DW-1:0]     obsAcc,
  input  logic [DW-1:0]     obsPsw,
  input  logic              stackOp,
  input  logic              stackPush,
  input  logic [DW-1:0]     spBefore,
  input  logic [DW-1:0]     spAfter,
  input  logic              fetchValid,
  input  logic [DW-1:0]     fetchOp,
  input  logic [DW-1:0]     fetchArg,
  input  logic              clearCode,
  output logic [CODE_W-1:0] excCode,
  output logic              haltReq
);
  ictxStrobes_t stb;
  logic [EV_N-1:0] evVec;

  ictx_control u_ctrl (
    .clk(clk), .rstN(rstN), .irqTake(irqTake), .irqLevel(irqLevel),
    .retiExec(retiExec), .clearCode(clearCode), .evVec(evVec),
    .stb(stb), .excCode(excCode), .haltReq(haltReq)
  );

  ictx_datapath #(
    .DW(DW), .PSW_USER_MASK(PSW_USER_MASK), .ILL_OP(ILL_OP),
    .MOV_DIR_OP(MOV_DIR_OP), .ACC_ADDR(ACC_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .enMask(enMask),
    .upperPresent(upperPresent), .obsSp(obsSp), .obsAcc(obsAcc),
    .obsPsw(obsPsw), .stackOp(stackOp), .stackPush(stackPush),
    .spBefore(spBefore), .spAfter(spAfter), .fetchValid(fetchValid),
    .fetchOp(fetchOp), .fetchArg(fetchArg), .evVec(evVec)
  );
endmodule

// File: rtl/ictx_guard_chk.sv
module ictx_guard_chk
  import ictx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [EV_N-1:0]   enMask,
  input logic              upperPresent,
  input logic              retiExec,
  input logic              stackOp,
  input logic              stackPush,
  input logic [DW-1:0]     spBefore,
  input logic [DW-1:0]     spAfter,
  input logic              fetchValid,
  input logic [DW-1:0]     fetchOp,
  input logic              clearCode,
  input logic [CODE_W-1:0] excCode,
  input logic              haltReq
);
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (excCode != 3'd0 && !clearCode) |=> $stable(excCode)); // R11
  AST_QUIET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clearCode && !fetchValid && !stackOp && !retiExec) |=> (excCode == 3'd0)); // R11
  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rstN)
    (excCode == 3'd0 && enMask[4] && fetchValid && fetchOp == 8'hA5 && !stackOp && !retiExec)
    |=> (excCode == 3'd5)); // R6
  AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (excCode == 3'd0 && enMask[3] && stackOp && stackPush && spAfter < spBefore && !retiExec)
    |=> (excCode == 3'd4)); // R4
  AST_UPPER_ABSENT: assert property (@(posedge clk) disable iff (!rstN)
    (excCode == 3'd0 && enMask[3] && stackOp && stackPush && spAfter[7] && !upperPresent && !retiExec)
    |=> (excCode == 3'd4)); // R5
  AST_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (excCode == 3'd0 && enMask == '0) |=> (excCode == 3'd0)); // R8
  AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(excCode) == 3'd0); // R11
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    excCode <= 3'd6); // R11
endmodule

bind ictx_guard ictx_guard_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_ictx_guard.sv
module test_ictx_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] enMask = 6'h3F;
  logic upperPresent = 1'b1;
  logic irqTake = 0, retiExec = 0, stackOp = 0, stackPush = 0, fetchValid = 0, clearCode = 0;
  logic [0:0] irqLevel = 0;
  logic [7:0] obsSp = 0, obsAcc = 0, obsPsw = 0, spBefore = 0, spAfter = 0, fetchOp = 0, fetchArg = 0;
  logic [2:0] excCode;
  logic haltReq;
  int nChk = 0, nBad = 0, cyc = 0;

  always #4 clk = ~clk;

  ictx_guard i_ictx_guard (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic chk(string req, logic [2:0] exp);
    nChk++;
    if (excCode !== exp || haltReq !== (exp != 0)) begin
      nBad++;
      $display("FAIL %s: code=%0d halt=%0d expected code=%0d halt=%0d",
               req, excCode, haltReq, exp, exp != 0);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    irqTake = 0; retiExec = 0; stackOp = 0; fetchValid = 0; clearCode = 0;
  endtask

  task automatic clr();
    clearCode = 1; tick();
  endtask

  task automatic enter(logic lvl, logic [7:0] sp, logic [7:0] acc, logic [7:0] psw);
    irqTake = 1; irqLevel = lvl; obsSp = sp; obsAcc = acc; obsPsw = psw; tick();
  endtask

  task automatic leave(logic [7:0] sp, logic [7:0] acc, logic [7:0] psw);
    retiExec = 1; obsSp = sp; obsAcc = acc; obsPsw = psw; tick();
  endtask

  task automatic fetch(logic [7:0] op, logic [7:0] arg);
    fetchValid = 1; fetchOp = op; fetchArg = arg; tick();
  endtask

  task automatic stk(logic push, logic [7:0] b, logic [7:0] a);
    stackOp = 1; stackPush = push; spBefore = b; spAfter = a; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset", 3'd0);
    rstN = 1;
    tick();
    chk("R12 after release", 3'd0);
    leave(8'h55, 8'h66, 8'h77);
    chk("R12/R10 return with no entry", 3'd0);

    // R6 R7: sweep all opcodes with the accumulator operand and another operand
    for (int op = 0; op < 256; op++) begin
      fetch(8'(op), 8'hE0);
      chk("R6/R7 opcode sweep", op == 8'hA5 ? 3'd5 : (op == 8'hE5 ? 3'd6 : 3'd0));
      clr();
      fetch(8'(op), 8'hE1);
      chk("R6/R7 opcode sweep other operand", op == 8'hA5 ? 3'd5 : 3'd0);
      clr();
    end

    // R4 R5: every push and pop, upper memory present and absent
    for (int u = 0; u < 2; u++) begin
      upperPresent = u[0];
      for (int s = 0; s < 256; s++) begin
        logic [7:0] nx, pv;
        nx = 8'(s + 1);
        pv = 8'(s - 1);
        stk(1'b1, 8'(s), nx);
        chk("R4/R5 push sweep", (s == 255 || (nx[7] && u == 0)) ? 3'd4 : 3'd0);
        clr();
        stk(1'b0, 8'(s), pv);
        chk("R4 pop sweep", s == 0 ? 3'd4 : 3'd0);
        clr();
      end
    end
    upperPresent = 1;

    // R1 R2 R3: single-bit disturbances of each preserved value
    for (int b = 0; b < 8; b++) begin
      enter(0, 8'h30, 8'h5A, 8'h81);
      leave(8'h30 ^ (8'd1 << b), 8'h5A, 8'h81);
      chk("R1 SP bit", 3'd1); clr();
      enter(0, 8'h30, 8'h5A, 8'h81);
      leave(8'h30, 8'h5A ^ (8'd1 << b), 8'h81);
      chk("R2 ACC bit", 3'd2); clr();
      enter(0, 8'h30, 8'h5A, 8'h81);
      leave(8'h30, 8'h5A, 8'h81 ^ (8'd1 << b));
      chk("R3 PSW bit", (b == 1 || b == 5) ? 3'd0 : 3'd3); clr();
    end

    // R9 nesting
    enter(0, 8'h10, 8'h01, 8'h00);
    enter(1, 8'h20, 8'h02, 8'h08);
    leave(8'h20, 8'h02, 8'h08);
    chk("R9 inner return matches own slot", 3'd0);
    leave(8'h10, 8'h01, 8'h00);
    chk("R9 outer return matches own slot", 3'd0);
    leave(8'hEE, 8'hEE, 8'hEE);
    chk("R10 return after all retired", 3'd0);
    enter(0, 8'h10, 8'h01, 8'h00);
    enter(1, 8'h20, 8'h02, 8'h00);
    leave(8'h10, 8'h02, 8'h00);
    chk("R9 inner checked against level 1", 3'd1);
    clr();
    leave(8'h10, 8'h01, 8'h00);
    chk("R9 outer slot intact", 3'd0);

    // R8: each check disabled alone, and enabled alone
    for (int e = 0; e < 6; e++) begin
      for (int m = 0; m < 2; m++) begin
        enMask = (m == 0) ? ~(6'd1 << e) : (6'd1 << e);
        upperPresent = (e != 3);
        case (e)
          0: begin enter(0, 8'h40, 8'h0, 8'h0); leave(8'h41, 8'h0, 8'h0); end
          1: begin enter(0, 8'h40, 8'h0, 8'h0); leave(8'h40, 8'h9, 8'h0); end
          2: begin enter(0, 8'h40, 8'h0, 8'h0); leave(8'h40, 8'h0, 8'h80); end
          3: stk(1'b1, 8'h7F, 8'h80);
          4: fetch(8'hA5, 8'h00);
          default: fetch(8'hE5, 8'hE0);
        endcase
        chk(m == 0 ? "R8 check disabled" : "R8 check enabled alone",
            m == 0 ? 3'd0 : 3'(e + 1));
        clr();
      end
    end
    enMask = 6'h3F;
    upperPresent = 1;

    // R11 coincident events, stickiness, clear with event
    enter(0, 8'h50, 8'h11, 8'h00);
    leave(8'h51, 8'h12, 8'h00);
    chk("R11 SP and ACC same cycle", 3'd1);
    clr();
    stackOp = 1; stackPush = 0; spBefore = 8'h00; spAfter = 8'hFF;
    fetchValid = 1; fetchOp = 8'hA5;
    tick();
    chk("R11 pop wrap with undefined opcode", 3'd4);
    fetch(8'hE5, 8'hE0);
    chk("R11 held against later event", 3'd4);
    clearCode = 1; fetchValid = 1; fetchOp = 8'hA5;
    tick();
    chk("R11 clear with event loads event", 3'd5);
    clr();
    chk("R11 clear alone", 3'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule